// File: doc/BRIEF.md
# Committed Store Buffer with Load Forwarding

This block sits between the address-generation stage and the data cache of an out-of-order core. A store enters it once its word address is known, and its data is written into the same entry in the same cycle. Entries stay speculative until the reorder buffer signals, one store at a time and oldest first, that a store has retired. Only retired entries may use the single cache write port. They leave in program order, one per cycle in which the port is granted.

A recovery flush drops every speculative entry at once. Entries that have already retired survive the flush and still drain. A load presents its address on the lookup port and, in the same cycle, learns one of two things. Either no buffered store covers its word, and it may read the cache, or the value comes from the youngest buffered store to that word. Every store in the buffer counts as older than the load being looked up.

Top module: `csq_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `wr_req_o` and `full_o` are 0, `alloc_ready_o` is 1, and every lookup misses.
- R2: When `alloc_valid_i` and `alloc_ready_o` are both high at a clock edge, the address and data are written into the youngest slot. The entry is visible to lookups from the next cycle.
- R3: When `DEPTH` entries are held, `full_o` is 1 and `alloc_ready_o` is 0. An allocation offered while full is dropped and leaves no entry behind.
- R4: A pulse on `commit_i` marks the oldest speculative entry as retired. A pulse when no speculative entry exists has no effect. An entry never requests the cache write port before it is retired.
- R5: `wr_req_o` presents the oldest entry, and only if it is retired. The entry is removed at the edge where `wr_grant_i` is also high. Entries leave in allocation order, one per granted cycle. While the port is not granted, the request, address and data stay unchanged.
- R6: `flush_i` discards every speculative entry, and none of them ever reaches the cache. A commit in the same cycle is applied first. An allocation in the same cycle is dropped.
- R7: A flush never removes or changes a retired entry.
- R8: With `ld_valid_i` high and no buffered entry on the same word, `ld_bypass_o` is 1 and `ld_hit_o` is 0. With `ld_valid_i` low, both are 0.
- R9: With a match, `ld_hit_o` is 1 and `ld_data_o` carries the data of the youngest matching entry.
- R10: Addresses are compared on word granularity: the low `log2(DW/8)` bits (bits 1:0 for 32-bit data) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Store offered for insertion |
| alloc_addr_i | input | AW | Store byte address |
| alloc_data_i | input | DW | Store data word |
| alloc_ready_o | output | 1 | Buffer can accept a store |
| commit_i | input | 1 | Retire the oldest speculative store |
| flush_i | input | 1 | Discard all speculative stores |
| ld_valid_i | input | 1 | Load lookup request |
| ld_addr_i | input | AW | Load byte address |
| ld_hit_o | output | 1 | Load data comes from the buffer |
| ld_bypass_o | output | 1 | Load may read the cache |
| ld_data_o | output | DW | Forwarded data |
| wr_req_o | output | 1 | Cache write request for the oldest retired store |
| wr_addr_o | output | AW | Cache write address |
| wr_data_o | output | DW | Cache write data |
| wr_grant_i | input | 1 | Cache write port granted this cycle |
| full_o | output | 1 | All entries occupied |

## Verification
The bench stores the same word twice and then checks that the second value is forwarded. A design that searched from the oldest entry would return stale data. It offers a store to a full buffer and looks for that address afterwards, which exposes a tail pointer that overruns the head. It flushes with retired entries present, and flushes together with a commit or an allocation. These cases catch designs that drop retired stores, let the flushed store slip in, or order the commit after the flush. It also holds the cache port ungranted and then drains a full wrapped buffer, checking every address in order. A design with a broken head pointer would reorder or repeat cache writes.

// File: rtl/csq_pkg.sv
package csq_pkg;
   localparam int unsigned CSQ_AW_DEF    = 32;
   localparam int unsigned CSQ_DW_DEF    = 32;
   localparam int unsigned CSQ_DEPTH_DEF = 8;

   // Outcome of a load lookup
   typedef enum logic [1:0] {
      LKP_IDLE   = 2'd0,
      LKP_BYPASS = 2'd1,
      LKP_FWD    = 2'd2
   } lkp_res_e;
endpackage

// File: rtl/csq_ptrs.sv
module csq_ptrs #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_req,
   input  logic          commit_req,
   input  logic          flush,
   input  logic          drain_req,
   output logic          alloc_fire,
   output logic          commit_fire,
   output logic          drain_fire,
   output logic [PW-1:0] head_idx,
   output logic [PW-1:0] cmt_idx,
   output logic [PW-1:0] tail_idx,
   output logic          full
);
   // pointers carry one extra wrap bit
   logic [PW:0] head_q, cmt_q, tail_q;
   logic [PW:0] head_d, cmt_d, tail_d;
   logic [PW:0] used;

   assign used        = tail_q - head_q;
   assign full        = (used == (PW+1)'(DEPTH));
   assign alloc_fire  = alloc_req & ~full & ~flush;
   assign commit_fire = commit_req & (cmt_q != tail_q);
   assign drain_fire  = drain_req & (head_q != cmt_q);

   always_comb begin
      head_d = head_q + (PW+1)'(drain_fire);
      cmt_d  = cmt_q + (PW+1)'(commit_fire);
      if (flush) tail_d = cmt_d;
      else       tail_d = tail_q + (PW+1)'(alloc_fire);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         cmt_q  <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_d;
         cmt_q  <= cmt_d;
         tail_q <= tail_d;
      end
   end

   assign head_idx = head_q[PW-1:0];
   assign cmt_idx  = cmt_q[PW-1:0];
   assign tail_idx = tail_q[PW-1:0];
endmodule

// File: rtl/csq_store.sv
module csq_store #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 32,
   parameter int unsigned DW    = 32,
   localparam int unsigned PW   = $clog2(DEPTH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     alloc_fire,
   input  logic [PW-1:0]            tail_idx,
   input  logic [AW-1:0]            alloc_addr,
   input  logic [DW-1:0]            alloc_data,
   input  logic                     commit_fire,
   input  logic [PW-1:0]            cmt_idx,
   input  logic                     drain_fire,
   input  logic [PW-1:0]            head_idx,
   input  logic                     flush,
   output logic [DEPTH-1:0]         valid_q,
   output logic [DEPTH-1:0]         retired_q,
   output logic [DEPTH-1:0][AW-1:0] addr_q,
   output logic [DEPTH-1:0][DW-1:0] data_q
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      localparam logic [PW-1:0] IDX = PW'(i);
      logic wr_here, ret_here, pop_here;

      assign wr_here  = alloc_fire  && (tail_idx == IDX);
      assign ret_here = commit_fire && (cmt_idx  == IDX);
      assign pop_here = drain_fire  && (head_idx == IDX);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[i]   <= 1'b0;
            retired_q[i] <= 1'b0;
         end else begin
            if (pop_here) begin
               valid_q[i]   <= 1'b0;
               retired_q[i] <= 1'b0;
            end else if (flush && !(retired_q[i] || ret_here)) begin
               valid_q[i]   <= 1'b0;
               retired_q[i] <= 1'b0;
            end else begin
               if (wr_here)  valid_q[i]   <= 1'b1;
               if (ret_here) retired_q[i] <= 1'b1;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (wr_here) begin
            addr_q[i] <= alloc_addr;
            data_q[i] <= alloc_data;
         end
      end
   end
endmodule

// File: rtl/csq_fwd.sv
module csq_fwd #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 32,
   parameter int unsigned DW    = 32,
   localparam int unsigned PW   = $clog2(DEPTH),
   localparam int unsigned OFS  = $clog2(DW/8)
) (
   input  logic [DEPTH-1:0]         valid_q,
   input  logic [DEPTH-1:0][AW-1:0] addr_q,
   input  logic [DEPTH-1:0][DW-1:0] data_q,
   input  logic [PW-1:0]            head_idx,
   input  logic                     ld_valid,
   input  logic [AW-1:0]            ld_addr,
   output csq_pkg::lkp_res_e        result,
   output logic [DW-1:0]            fwd_data
);
   logic [DEPTH-1:0] match;
   logic [PW-1:0]    scan_idx;
   logic             any_hit;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign match[i] = valid_q[i] && (addr_q[i][AW-1:OFS] == ld_addr[AW-1:OFS]);
   end

   // scan oldest to youngest; the last hit wins
   always_comb begin
      any_hit  = 1'b0;
      fwd_data = '0;
      scan_idx = head_idx;
      for (int k = 0; k < DEPTH; k++) begin
         scan_idx = head_idx + PW'(k);
         if (match[scan_idx]) begin
            any_hit  = 1'b1;
            fwd_data = data_q[scan_idx];
         end
      end
   end

   always_comb begin
      if (!ld_valid)    result = csq_pkg::LKP_IDLE;
      else if (any_hit) result = csq_pkg::LKP_FWD;
      else              result = csq_pkg::LKP_BYPASS;
   end
endmodule

// File: rtl/csq_store_buffer.sv
module csq_store_buffer #(
   parameter int unsigned DEPTH = csq_pkg::CSQ_DEPTH_DEF,
   parameter int unsigned AW    = csq_pkg::CSQ_AW_DEF,
   parameter int unsigned DW    = csq_pkg::CSQ_DW_DEF,
   localparam int unsigned PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_valid_i,
   input  logic [AW-1:0] alloc_addr_i,
   input  logic [DW-1:0] alloc_data_i,
   output logic          alloc_ready_o,
   input  logic          commit_i,
   input  logic          flush_i,
   input  logic          ld_valid_i,
   input  logic [AW-1:0] ld_addr_i,
   output logic          ld_hit_o,
   output logic          ld_bypass_o,
   output logic [DW-1:0] ld_data_o,
   output logic          wr_req_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [DW-1:0] wr_data_o,
   input  logic          wr_grant_i,
   output logic          full_o
);
   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("csq_store_buffer: DEPTH must be a power of two >= 2");
   end
   if (DW < 8 || (DW % 8) != 0 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("csq_store_buffer: DW must be a power-of-two byte multiple");
   end
   if (AW <= $clog2(DW/8)) begin : g_bad_aw
      $error("csq_store_buffer: AW too small for word offset");
   end

   logic                     alloc_fire, commit_fire, drain_fire, full;
   logic [PW-1:0]            head_idx, cmt_idx, tail_idx;
   logic [DEPTH-1:0]         valid_q, retired_q;
   logic [DEPTH-1:0][AW-1:0] addr_q;
   logic [DEPTH-1:0][DW-1:0] data_q;
   csq_pkg::lkp_res_e        lkp_res;
   logic                     head_ready;

   assign head_ready = valid_q[head_idx] && retired_q[head_idx];

   csq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_req   (alloc_valid_i),
      .commit_req  (commit_i),
      .flush       (flush_i),
      .drain_req   (head_ready && wr_grant_i),
      .alloc_fire  (alloc_fire),
      .commit_fire (commit_fire),
      .drain_fire  (drain_fire),
      .head_idx    (head_idx),
      .cmt_idx     (cmt_idx),
      .tail_idx    (tail_idx),
      .full        (full)
   );

   csq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_fire  (alloc_fire),
      .tail_idx    (tail_idx),
      .alloc_addr  (alloc_addr_i),
      .alloc_data  (alloc_data_i),
      .commit_fire (commit_fire),
      .cmt_idx     (cmt_idx),
      .drain_fire  (drain_fire),
      .head_idx    (head_idx),
      .flush       (flush_i),
      .valid_q     (valid_q),
      .retired_q   (retired_q),
      .addr_q      (addr_q),
      .data_q      (data_q)
   );

   csq_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
      .valid_q  (valid_q),
      .addr_q   (addr_q),
      .data_q   (data_q),
      .head_idx (head_idx),
      .ld_valid (ld_valid_i),
      .ld_addr  (ld_addr_i),
      .result   (lkp_res),
      .fwd_data (ld_data_o)
   );

   assign ld_hit_o      = (lkp_res == csq_pkg::LKP_FWD);
   assign ld_bypass_o   = (lkp_res == csq_pkg::LKP_BYPASS);
   assign wr_req_o      = head_ready;
   assign wr_addr_o     = addr_q[head_idx];
   assign wr_data_o     = data_q[head_idx];
   assign full_o        = full;
   assign alloc_ready_o = ~full;
endmodule

// File: rtl/csq_chk.sv
module csq_chk #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 32,
   parameter int unsigned DW    = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DEPTH-1:0] valid_q,
   input logic [DEPTH-1:0] retired_q,
   input logic             flush_i,
   input logic             full_o,
   input logic             wr_req_o,
   input logic             wr_grant_i,
   input logic [AW-1:0]    wr_addr_o,
   input logic [DW-1:0]    wr_data_o,
   input logic             ld_hit_o,
   input logic             ld_bypass_o
);
   // R3
   full_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> (&valid_q));

   // R4
   retire_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(valid_q & retired_q) <= $past($countones(valid_q & retired_q)) + 1));

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !wr_grant_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

   // R6
   flush_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> ((valid_q & ~retired_q) == '0));

   // R7
   retired_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_req_o && wr_grant_i) |=>
         ($countones(valid_q & retired_q) >= $past($countones(valid_q & retired_q))));

   // R8
   lkp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_hit_o && ld_bypass_o));
endmodule

bind csq_store_buffer csq_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .valid_q     (valid_q),
   .retired_q   (retired_q),
   .flush_i     (flush_i),
   .full_o      (full_o),
   .wr_req_o    (wr_req_o),
   .wr_grant_i  (wr_grant_i),
   .wr_addr_o   (wr_addr_o),
   .wr_data_o   (wr_data_o),
   .ld_hit_o    (ld_hit_o),
   .ld_bypass_o (ld_bypass_o)
);

// File: tb/csq_store_buffer_bench.sv
module csq_store_buffer_bench;
   localparam int unsigned DEPTH = 8;
   localparam int unsigned AW    = 32;
   localparam int unsigned DW    = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alloc_valid_i = 1'b0;
   logic [AW-1:0] alloc_addr_i = '0;
   logic [DW-1:0] alloc_data_i = '0;
   logic          alloc_ready_o;
   logic          commit_i = 1'b0;
   logic          flush_i = 1'b0;
   logic          ld_valid_i = 1'b0;
   logic [AW-1:0] ld_addr_i = '0;
   logic          ld_hit_o, ld_bypass_o;
   logic [DW-1:0] ld_data_o;
   logic          wr_req_o;
   logic [AW-1:0] wr_addr_o;
   logic [DW-1:0] wr_data_o;
   logic          wr_grant_i = 1'b0;
   logic          full_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   csq_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_csq_store_buffer (.*);

   typedef struct packed {
      logic          is_lookup;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic          exp_hit;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 32'h100, 32'h11, 1'b0},
      '{1'b0, 32'h104, 32'h22, 1'b0},
      '{1'b0, 32'h100, 32'h33, 1'b0},
      '{1'b1, 32'h100, 32'h33, 1'b1},   // R9 youngest of two
      '{1'b1, 32'h102, 32'h33, 1'b1},   // R10 low bits ignored
      '{1'b1, 32'h108, 32'h0,  1'b0},   // R8 miss
      '{1'b1, 32'h104, 32'h22, 1'b1}    // R2 stored data
   };

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic alloc(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      alloc_valid_i = 1'b1; alloc_addr_i = a; alloc_data_i = d;
      @(negedge clk);
      alloc_valid_i = 1'b0;
   endtask

   task automatic commit1();
      @(negedge clk); commit_i = 1'b1;
      @(negedge clk); commit_i = 1'b0;
   endtask

   task automatic lookup(input logic [AW-1:0] a, input bit exp_hit, input logic [DW-1:0] exp_d, input string req);
      ld_valid_i = 1'b1; ld_addr_i = a;
      #1;
      check(ld_hit_o == exp_hit && ld_bypass_o == !exp_hit, req, {63'b0, ld_hit_o}, {63'b0, exp_hit});
      if (exp_hit) check(ld_data_o == exp_d, req, ld_data_o, exp_d);
      ld_valid_i = 1'b0;
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!wr_req_o && !full_o && alloc_ready_o, "R1", {wr_req_o, full_o, alloc_ready_o}, 3'b001);
      lookup(32'h100, 1'b0, '0, "R1");

      for (int v = 0; v < NV; v++) begin
         if (VEC[v].is_lookup) begin
            @(negedge clk);
            lookup(VEC[v].addr, VEC[v].exp_hit, VEC[v].data, "R9/R10/R8/R2");
         end else begin
            alloc(VEC[v].addr, VEC[v].data);
         end
      end

      // R4 nothing retired: no request even with grant
      wr_grant_i = 1'b1;
      repeat (2) @(negedge clk);
      check(!wr_req_o, "R4", wr_req_o, 0);
      wr_grant_i = 1'b0;

      commit1();
      check(wr_req_o && wr_addr_o == 32'h100 && wr_data_o == 32'h11, "R4", wr_addr_o, 32'h100);
      repeat (2) @(negedge clk);
      check(wr_req_o && wr_addr_o == 32'h100, "R5", wr_addr_o, 32'h100);
      commit1();

      // R6/R7 flush drops 0x100/0x33, keeps retired entries
      @(negedge clk); flush_i = 1'b1;
      @(negedge clk); flush_i = 1'b0;
      lookup(32'h100, 1'b1, 32'h11, "R6");
      lookup(32'h104, 1'b1, 32'h22, "R7");

      // R6 flush beats allocation
      @(negedge clk);
      flush_i = 1'b1; alloc_valid_i = 1'b1; alloc_addr_i = 32'h200; alloc_data_i = 32'h99;
      @(negedge clk);
      flush_i = 1'b0; alloc_valid_i = 1'b0;
      lookup(32'h200, 1'b0, '0, "R6");

      // R5 ordered drain
      wr_grant_i = 1'b1;
      @(negedge clk);
      check(wr_req_o && wr_addr_o == 32'h104 && wr_data_o == 32'h22, "R5", wr_addr_o, 32'h104);
      @(negedge clk);
      check(!wr_req_o, "R5", wr_req_o, 0);
      wr_grant_i = 1'b0;
      lookup(32'h100, 1'b0, '0, "R5");

      // R3 fill (wraps around the ring)
      for (int i = 0; i < DEPTH; i++) alloc(32'h300 + 4*i, 32'hA0 + i);
      check(full_o && !alloc_ready_o, "R3", {full_o, alloc_ready_o}, 2'b10);
      alloc(32'h400, 32'h55);
      lookup(32'h400, 1'b0, '0, "R3");
      lookup(32'h31C, 1'b1, 32'hA7, "R3");

      for (int i = 0; i < DEPTH; i++) commit1();
      commit1(); // R4 extra commit has no effect
      wr_grant_i = 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
         check(wr_req_o && wr_addr_o == 32'h300 + 4*i && wr_data_o == 32'hA0 + i, "R5",
               wr_addr_o, 32'h300 + 4*i);
         @(negedge clk);
      end
      wr_grant_i = 1'b0;
      check(!wr_req_o && !full_o, "R5", {wr_req_o, full_o}, 2'b00);

      // R4 stray commit earlier must not retire the new store
      alloc(32'h600, 32'h66);
      wr_grant_i = 1'b1;
      @(negedge clk);
      check(!wr_req_o, "R4", wr_req_o, 0);
      wr_grant_i = 1'b0;
      @(negedge clk); flush_i = 1'b1;
      @(negedge clk); flush_i = 1'b0;

      // R6 commit and flush in the same cycle
      alloc(32'h500, 32'hA);
      alloc(32'h504, 32'hB);
      @(negedge clk); commit_i = 1'b1; flush_i = 1'b1;
      @(negedge clk); commit_i = 1'b0; flush_i = 1'b0;
      check(wr_req_o && wr_addr_o == 32'h500 && wr_data_o == 32'hA, "R6", wr_addr_o, 32'h500);
      lookup(32'h504, 1'b0, '0, "R6");
      wr_grant_i = 1'b1;
      @(negedge clk);
      wr_grant_i = 1'b0;
      check(!wr_req_o, "R6", wr_req_o, 0);

      // R8 idle lookup
      ld_valid_i = 1'b0; ld_addr_i = 32'h500;
      #1;
      check(!ld_hit_o && !ld_bypass_o, "R8", {ld_hit_o, ld_bypass_o}, 2'b00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule